// File: doc/BRIEF.md
# 32-bit Integer ALU with Four-Bit Operation Code

This block is the integer arithmetic and logic unit of a simple load/store datapath. It is purely combinational: two operands and a four-bit operation code go in, and in the same cycle a result word, a zero flag, a carry-out and a signed-overflow flag come out. The block performs bitwise AND, OR and NOR, two's-complement addition and subtraction, and a signed less-than compare that yields a single 0/1 bit.

Internally the word is a ripple chain of one-bit slices. Each slice can invert its A input and its B input, and has an adder, an AND gate, an OR gate and a pass-through for a "less" bit. The operation code drives these controls directly. Bit 3 inverts A. Bit 2 inverts B and also feeds a one into the carry of slice 0. The two low bits pick which slice output becomes the result bit. Subtraction therefore reuses the adder as A + ~B + 1. NOR is the AND of both inverted operands. The compare takes the sign of A − B, corrected by its overflow, and routes that bit back into slice 0. The most significant slice is a separate variant that also produces the overflow and compare outputs. The zero detector is built as a grouped OR tree whose group size is a parameter.

Top module: `alu32_core`

## Requirements
- R1: Code 0000 returns the bitwise AND of A and B.
- R2: Code 0001 returns the bitwise OR of A and B.
- R3: Code 0010 returns the low 32 bits of A + B. The carry output is bit 32 of that unsigned sum.
- R4: Code 0110 returns the low 32 bits of A − B. The carry output is the carry out of A + ~B + 1, so it is 1 exactly when A ≥ B as unsigned numbers.
- R5: Code 0111 returns 1 in bit 0 when A < B as signed numbers and 0 otherwise, with bits 31..1 zero. The answer stays correct when A − B overflows. Carry and overflow report the internal A − B.
- R6: Code 1100 returns the bitwise NOR of A and B.
- R7: For code 0010 the overflow output is high exactly when A and B have the same sign and the result sign differs from it.
- R8: For codes 0110 and 0111 the overflow output is high exactly when A and B differ in sign and the sign of A − B differs from the sign of A.
- R9: For codes 0000, 0001 and 1100 the carry and overflow outputs are low.
- R10: For the six defined codes the zero output is high exactly when all 32 result bits are zero.
- R11: Every other code (for example 0011, 1111) gives a zero result, with the zero, carry and overflow outputs all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| op_i | input | 4 | Operation code |
| result_o | output | 32 | Result word |
| zero_o | output | 1 | Result is all zeros (defined codes only) |
| carry_o | output | 1 | Carry out of the most significant slice for arithmetic codes |
| ovf_o | output | 1 | Signed overflow for arithmetic codes |

## Verification
The hardest case to reach is a signed compare whose internal subtraction overflows. Here the raw sign bit of A − B gives the wrong answer, and only the overflow correction fed back into slice 0 fixes it. Random operands seldom differ in sign by a large enough margin to reach it. The stimulus table therefore holds compares of the most negative value against a small positive number, and of the largest positive value against −1. Directed pairs at the two extremes of the signed range follow. A pseudo-random sweep then runs every one of the sixteen codes, including the undefined ones, against an independent reference model. This sweep covers carry, overflow and zero detection over broad operand patterns.

// File: rtl/alu32_pkg.sv
`timescale 1ns/1ps
package alu32_pkg;

   // Slice output selection, taken from the two low code bits.
   typedef enum logic [1:0] {
      PICK_AND  = 2'b00,
      PICK_OR   = 2'b01,
      PICK_SUM  = 2'b10,
      PICK_LESS = 2'b11
   } pick_e;

   // Defined operation codes.
   typedef enum logic [3:0] {
      OPC_AND = 4'b0000,
      OPC_OR  = 4'b0001,
      OPC_ADD = 4'b0010,
      OPC_SUB = 4'b0110,
      OPC_SLT = 4'b0111,
      OPC_NOR = 4'b1100
   } opc_e;

   // Decoded control bundle.
   typedef struct packed {
      logic  valid;
      logic  inv_a;
      logic  inv_b;
      logic  arith;
      pick_e pick;
   } ctrl_t;

endpackage

// File: rtl/alu32_decode.sv
`timescale 1ns/1ps
module alu32_decode
   import alu32_pkg::*;
(
   input  logic [3:0] op_i,
   output ctrl_t      ctrl_o
);

   logic known;

   always_comb begin
      unique case (op_i)
         OPC_AND, OPC_OR, OPC_ADD,
         OPC_SUB, OPC_SLT, OPC_NOR: known = 1'b1;
         default:                   known = 1'b0;
      endcase
   end

   always_comb begin
      ctrl_o.valid = known;
      ctrl_o.inv_a = op_i[3];
      ctrl_o.inv_b = op_i[2];
      ctrl_o.pick  = pick_e'(op_i[1:0]);
      // Adder flags are meaningful only when the sum or less path is picked.
      ctrl_o.arith = known & op_i[1];
   end

endmodule

// File: rtl/alu32_slice.sv
`timescale 1ns/1ps
module alu32_slice
   import alu32_pkg::*;
(
   input  logic  a_i,
   input  logic  b_i,
   input  logic  inv_a_i,
   input  logic  inv_b_i,
   input  logic  c_in_i,
   input  logic  less_i,
   input  pick_e pick_i,
   output logic  res_o,
   output logic  c_out_o
);

   logic aa;
   logic bb;
   logic sum;

   assign aa      = a_i ^ inv_a_i;
   assign bb      = b_i ^ inv_b_i;
   assign sum     = aa ^ bb ^ c_in_i;
   assign c_out_o = (aa & bb) | (aa & c_in_i) | (bb & c_in_i);

   always_comb begin
      unique case (pick_i)
         PICK_AND:  res_o = aa & bb;
         PICK_OR:   res_o = aa | bb;
         PICK_SUM:  res_o = sum;
         PICK_LESS: res_o = less_i;
         default:   res_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/alu32_msb_slice.sv
`timescale 1ns/1ps
module alu32_msb_slice
   import alu32_pkg::*;
(
   input  logic  a_i,
   input  logic  b_i,
   input  logic  inv_a_i,
   input  logic  inv_b_i,
   input  logic  c_in_i,
   input  pick_e pick_i,
   output logic  res_o,
   output logic  c_out_o,
   output logic  ovf_o,
   output logic  set_o
);

   logic aa;
   logic bb;
   logic sum;

   assign aa      = a_i ^ inv_a_i;
   assign bb      = b_i ^ inv_b_i;
   assign sum     = aa ^ bb ^ c_in_i;
   assign c_out_o = (aa & bb) | (aa & c_in_i) | (bb & c_in_i);

   // Signed overflow: carry into the sign position differs from carry out.
   assign ovf_o   = c_in_i ^ c_out_o;
   // Overflow-corrected sign of the difference, routed back to bit 0.
   assign set_o   = sum ^ ovf_o;

   always_comb begin
      unique case (pick_i)
         PICK_AND:  res_o = aa & bb;
         PICK_OR:   res_o = aa | bb;
         PICK_SUM:  res_o = sum;
         PICK_LESS: res_o = 1'b0;
         default:   res_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/alu32_chain.sv
`timescale 1ns/1ps
module alu32_chain
   import alu32_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             inv_a_i,
   input  logic             inv_b_i,
   input  pick_e            pick_i,
   output logic [WIDTH-1:0] res_o,
   output logic             carry_o,
   output logic             ovf_o
);

   localparam int MSB = WIDTH - 1;

   logic [WIDTH:0] cy;
   logic           set_w;

   // Inverting B also supplies the +1 of the two's-complement negate.
   assign cy[0]   = inv_b_i;
   assign carry_o = cy[WIDTH];

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i == MSB) begin : g_msb
         alu32_msb_slice u_slice (
            .a_i     (a_i[i]),
            .b_i     (b_i[i]),
            .inv_a_i (inv_a_i),
            .inv_b_i (inv_b_i),
            .c_in_i  (cy[i]),
            .pick_i  (pick_i),
            .res_o   (res_o[i]),
            .c_out_o (cy[i+1]),
            .ovf_o   (ovf_o),
            .set_o   (set_w)
         );
      end else if (i == 0) begin : g_lsb
         alu32_slice u_slice (
            .a_i     (a_i[i]),
            .b_i     (b_i[i]),
            .inv_a_i (inv_a_i),
            .inv_b_i (inv_b_i),
            .c_in_i  (cy[i]),
            .less_i  (set_w),
            .pick_i  (pick_i),
            .res_o   (res_o[i]),
            .c_out_o (cy[i+1])
         );
      end else begin : g_mid
         alu32_slice u_slice (
            .a_i     (a_i[i]),
            .b_i     (b_i[i]),
            .inv_a_i (inv_a_i),
            .inv_b_i (inv_b_i),
            .c_in_i  (cy[i]),
            .less_i  (1'b0),
            .pick_i  (pick_i),
            .res_o   (res_o[i]),
            .c_out_o (cy[i+1])
         );
      end
   end

endmodule

// File: rtl/alu32_flags.sv
`timescale 1ns/1ps
module alu32_flags #(
   parameter int WIDTH      = 32,
   parameter int ZERO_GROUP = 8
) (
   input  logic [WIDTH-1:0] raw_i,
   input  logic             valid_i,
   input  logic             arith_i,
   input  logic             carry_i,
   input  logic             ovf_i,
   output logic [WIDTH-1:0] result_o,
   output logic             zero_o,
   output logic             carry_o,
   output logic             ovf_o
);

   localparam int GROUPS = WIDTH / ZERO_GROUP;

   if (ZERO_GROUP < 1 || (WIDTH % ZERO_GROUP) != 0) begin : g_bad_group
      $error("alu32_flags: ZERO_GROUP must divide WIDTH");
   end

   logic any_set;

   assign result_o = valid_i ? raw_i : '0;
   assign carry_o  = arith_i & carry_i;
   assign ovf_o    = arith_i & ovf_i;

   if (GROUPS <= 1) begin : g_flat
      assign any_set = |raw_i;
   end else begin : g_tree
      logic [GROUPS-1:0] grp;
      for (genvar g = 0; g < GROUPS; g++) begin : g_grp
         assign grp[g] = |raw_i[g*ZERO_GROUP +: ZERO_GROUP];
      end
      assign any_set = |grp;
   end

   assign zero_o = valid_i & ~any_set;

endmodule

// File: rtl/alu32_core.sv
`timescale 1ns/1ps
module alu32_core
   import alu32_pkg::*;
#(
   parameter int WIDTH      = 32,
   parameter int ZERO_GROUP = 8
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [3:0]       op_i,
   output logic [WIDTH-1:0] result_o,
   output logic             zero_o,
   output logic             carry_o,
   output logic             ovf_o
);

   if (WIDTH < 2) begin : g_bad_width
      $error("alu32_core: WIDTH must be at least 2");
   end

   ctrl_t            ctrl;
   logic [WIDTH-1:0] raw;
   logic             chain_carry;
   logic             chain_ovf;

   alu32_decode u_decode (
      .op_i   (op_i),
      .ctrl_o (ctrl)
   );

   alu32_chain #(
      .WIDTH (WIDTH)
   ) u_chain (
      .a_i     (a_i),
      .b_i     (b_i),
      .inv_a_i (ctrl.inv_a),
      .inv_b_i (ctrl.inv_b),
      .pick_i  (ctrl.pick),
      .res_o   (raw),
      .carry_o (chain_carry),
      .ovf_o   (chain_ovf)
   );

   alu32_flags #(
      .WIDTH      (WIDTH),
      .ZERO_GROUP (ZERO_GROUP)
   ) u_flags (
      .raw_i    (raw),
      .valid_i  (ctrl.valid),
      .arith_i  (ctrl.arith),
      .carry_i  (chain_carry),
      .ovf_i    (chain_ovf),
      .result_o (result_o),
      .zero_o   (zero_o),
      .carry_o  (carry_o),
      .ovf_o    (ovf_o)
   );

endmodule

// File: rtl/alu32_core_chk.sv
`timescale 1ns/1ps
module alu32_core_chk #(
   parameter int WIDTH = 32
) (
   input logic [WIDTH-1:0] a_i,
   input logic [WIDTH-1:0] b_i,
   input logic [3:0]       op_i,
   input logic [WIDTH-1:0] result_o,
   input logic             zero_o,
   input logic             carry_o,
   input logic             ovf_o
);

   localparam int MSB = WIDTH - 1;

   logic [WIDTH:0] add_ref;
   logic [WIDTH:0] sub_ref;
   logic           defined;

   always_comb begin
      add_ref = {1'b0, a_i} + {1'b0, b_i};
      sub_ref = {1'b0, a_i} + {1'b0, ~b_i} + {{WIDTH{1'b0}}, 1'b1};
      defined = (op_i == 4'b0000) || (op_i == 4'b0001) || (op_i == 4'b0010) ||
                (op_i == 4'b0110) || (op_i == 4'b0111) || (op_i == 4'b1100);
   end

   always_comb begin
      if (op_i == 4'b0000) AST_AND_RESULT: assert (result_o == (a_i & b_i)); // R1
      if (op_i == 4'b0001) AST_OR_RESULT: assert (result_o == (a_i | b_i)); // R2
      if (op_i == 4'b0010) AST_ADD_SUM: assert ({carry_o, result_o} == add_ref); // R3
      if (op_i == 4'b0110) AST_SUB_DIFF: assert ({carry_o, result_o} == sub_ref); // R4
      if (op_i == 4'b0111) AST_SLT_BIT: assert (result_o == {{MSB{1'b0}}, ($signed(a_i) < $signed(b_i))}); // R5
      if (op_i == 4'b1100) AST_NOR_RESULT: assert (result_o == ~(a_i | b_i)); // R6
      if (op_i == 4'b0010) AST_ADD_OVERFLOW: assert (ovf_o == ((a_i[MSB] == b_i[MSB]) && (result_o[MSB] != a_i[MSB]))); // R7
      if (op_i == 4'b0110 || op_i == 4'b0111) AST_SUB_OVERFLOW: assert (ovf_o == ((a_i[MSB] != b_i[MSB]) && (sub_ref[MSB] != a_i[MSB]))); // R8
      if (op_i == 4'b0000 || op_i == 4'b0001 || op_i == 4'b1100) AST_NO_OVERFLOW: assert (!carry_o && !ovf_o); // R9
      if (defined) AST_ZERO_FLAG: assert (zero_o == (result_o == '0)); // R10
      if (!defined) AST_UNDEFINED_QUIET: assert (result_o == '0 && !zero_o && !carry_o && !ovf_o); // R11
   end

endmodule

bind alu32_core alu32_core_chk #(.WIDTH(WIDTH)) u_chk (
   .a_i      (a_i),
   .b_i      (b_i),
   .op_i     (op_i),
   .result_o (result_o),
   .zero_o   (zero_o),
   .carry_o  (carry_o),
   .ovf_o    (ovf_o)
);

// File: tb/alu32_core_tb_top.sv
`timescale 1ns/1ps
module alu32_core_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] a;
   logic [31:0] b;
   logic [3:0]  op;
   logic [31:0] res;
   logic        zf;
   logic        cf;
   logic        vf;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   alu32_core dut_i (
      .a_i      (a),
      .b_i      (b),
      .op_i     (op),
      .result_o (res),
      .zero_o   (zf),
      .carry_o  (cf),
      .ovf_o    (vf)
   );

   // {op, a, b, result, zero, carry, overflow}
   localparam int NVEC = 16;
   localparam logic [102:0] VEC [NVEC] = '{
      {4'b0000, 32'hF0F0_00FF, 32'h0FF0_0F0F, 32'h00F0_000F, 1'b0, 1'b0, 1'b0}, // R1
      {4'b0000, 32'hAAAA_AAAA, 32'h5555_5555, 32'h0000_0000, 1'b1, 1'b0, 1'b0}, // R1 R10
      {4'b0001, 32'hF0F0_00FF, 32'h0FF0_0F0F, 32'hFFF0_0FFF, 1'b0, 1'b0, 1'b0}, // R2
      {4'b0010, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 1'b0, 1'b0, 1'b1}, // R3 R7
      {4'b0010, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b1, 1'b1, 1'b0}, // R3 R10
      {4'b0010, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 1'b1, 1'b1, 1'b1}, // R7
      {4'b0110, 32'h0000_0005, 32'h0000_0007, 32'hFFFF_FFFE, 1'b0, 1'b0, 1'b0}, // R4
      {4'b0110, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 1'b0, 1'b1, 1'b1}, // R4 R8
      {4'b0110, 32'h1234_5678, 32'h1234_5678, 32'h0000_0000, 1'b1, 1'b1, 1'b0}, // R4 R10
      {4'b0111, 32'h8000_0000, 32'h0000_0001, 32'h0000_0001, 1'b0, 1'b1, 1'b1}, // R5 overflowing compare
      {4'b0111, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 1'b0, 1'b1}, // R5 overflowing compare
      {4'b0111, 32'h0000_0003, 32'h0000_0003, 32'h0000_0000, 1'b1, 1'b1, 1'b0}, // R5
      {4'b1100, 32'h0000_FFFF, 32'h00FF_0000, 32'hFF00_0000, 1'b0, 1'b0, 1'b0}, // R6 R9
      {4'b1100, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b0, 1'b0}, // R6 R10
      {4'b0011, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 1'b0, 1'b0}, // R11
      {4'b1111, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, 1'b0}  // R11
   };

   function automatic string res_tag(logic [3:0] o);
      case (o)
         4'b0000: return "R1";
         4'b0001: return "R2";
         4'b0010: return "R3";
         4'b0110: return "R4";
         4'b0111: return "R5";
         4'b1100: return "R6";
         default: return "R11";
      endcase
   endfunction

   function automatic string flag_tag(logic [3:0] o);
      case (o)
         4'b0010: return "R7";
         4'b0110: return "R8";
         4'b0111: return "R5";
         4'b0000, 4'b0001, 4'b1100: return "R9";
         default: return "R11";
      endcase
   endfunction

   // Reference model from the requirements: {result, zero, carry, overflow}
   function automatic logic [34:0] model(logic [3:0] o, logic [31:0] x, logic [31:0] y);
      logic [32:0] s;
      logic [31:0] r;
      logic        c;
      logic        v;
      logic        ok;
      r = '0; c = 1'b0; v = 1'b0; ok = 1'b1;
      case (o)
         4'b0000: r = x & y;
         4'b0001: r = x | y;
         4'b1100: r = ~(x | y);
         4'b0010: begin
            s = {1'b0, x} + {1'b0, y};
            r = s[31:0]; c = s[32];
            v = (x[31] == y[31]) && (r[31] != x[31]);
         end
         4'b0110, 4'b0111: begin
            s = {1'b0, x} + {1'b0, ~y} + 33'd1;
            c = s[32];
            v = (x[31] != y[31]) && (s[31] != x[31]);
            if (o == 4'b0110) r = s[31:0];
            else              r = {31'd0, ($signed(x) < $signed(y))};
         end
         default: ok = 1'b0;
      endcase
      return {r, ok && (r == 32'd0), c, v};
   endfunction

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic apply(logic [3:0] o, logic [31:0] x, logic [31:0] y);
      @(posedge clk);
      op = o; a = x; b = y;
      @(negedge clk);
   endtask

   task automatic expect_all(logic [31:0] er, logic ez, logic ec, logic ev);
      check(res_tag(op), "result", res, er);
      check((op == 4'b0000 || op == 4'b0001 || op == 4'b0010 || op == 4'b0110 ||
             op == 4'b0111 || op == 4'b1100) ? "R10" : "R11", "zero", {31'd0, zf}, {31'd0, ez});
      check(flag_tag(op), "carry", {31'd0, cf}, {31'd0, ec});
      check(flag_tag(op), "overflow", {31'd0, vf}, {31'd0, ev});
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #100000;
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [31:0] lfsr_a;
      logic [31:0] lfsr_b;
      logic [34:0] m;
      op = 4'b0000; a = '0; b = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // Reset state: zero operands with the AND code (R1, R10)
      expect_all(32'd0, 1'b1, 1'b0, 1'b0);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         apply(VEC[i][102:99], VEC[i][98:67], VEC[i][66:35]);
         expect_all(VEC[i][34:3], VEC[i][2], VEC[i][1], VEC[i][0]);
      end

      // R5 signed extremes and sign-only differences
      apply(4'b0111, 32'h8000_0000, 32'h7FFF_FFFF); check("R5", "min<max", res, 32'd1);
      apply(4'b0111, 32'h7FFF_FFFF, 32'h8000_0000); check("R5", "max<min", res, 32'd0);
      apply(4'b0111, 32'hFFFF_FFFF, 32'h0000_0000); check("R5", "-1<0", res, 32'd1);
      apply(4'b0111, 32'h0000_0000, 32'hFFFF_FFFF); check("R5", "0<-1", res, 32'd0);
      // R8 subtraction of the most negative value
      apply(4'b0110, 32'h0000_0000, 32'h8000_0000); check("R8", "0-min ovf", {31'd0, vf}, 32'd1);

      // Sweep of all sixteen codes with pseudo-random operands
      lfsr_a = 32'h1ACE_B00C;
      lfsr_b = 32'h8BAD_F00D;
      for (int n = 0; n < 120; n++) begin
         for (int k = 0; k < 16; k++) begin
            apply(4'(k), lfsr_a, lfsr_b);
            m = model(4'(k), lfsr_a, lfsr_b);
            expect_all(m[34:3], m[2], m[1], m[0]);
         end
         lfsr_a = {lfsr_a[30:0], lfsr_a[31] ^ lfsr_a[21] ^ lfsr_a[1] ^ lfsr_a[0]};
         lfsr_b = {lfsr_b[30:0], lfsr_b[31] ^ lfsr_b[21] ^ lfsr_b[1] ^ lfsr_b[0]};
         if (n % 4 == 3) lfsr_b = lfsr_a ^ {lfsr_b[31], 31'd0};
      end
      finish_run();
   end

endmodule